// File: doc/BRIEF.md
# Clock Trim Calibrator

This block sits in the divider chain between a 32,768 Hz crystal clock and the one-second tick of a real-time clock. It trims the clock's long-term rate digitally, so no trim capacitors are needed. A 5-bit magnitude and a sign select how many minutes of a repeating 64-minute window have one second altered. In each such minute the first second is either shortened by one divide-by-256 period or lengthened by half of one. Shortening speeds the clock up and lengthening slows it down.

The block also drives a frequency-test square wave. This wave is taken from a free-running divider ahead of the correction point, so a tester can measure the raw crystal error whatever trim is loaded. A stop input freezes and clears every counter, as if the oscillator were halted. On release, counting resumes from the start of a second, at minute 0 of the window.

Top module: `rtc_trim_calibrator`

## Requirements
- R1: After reset is released, with `stop_i` low, `tick_o`, `minute_o` and `ft_512_o` are low. The first `tick_o` appears after L-1 clock edges, where L is the length of second 0 under R2 to R5.
- R2: An untrimmed second lasts exactly 2^(PRE_W+POST_W) clock cycles (32,768 by default). This is the spacing between successive `tick_o` pulses.
- R3: With `cal_pos_i`=1, a trimmed second is 2^PRE_W cycles (256) shorter than an untrimmed one.
- R4: With `cal_pos_i`=0, a trimmed second is 2^(PRE_W-1) cycles (128) longer than an untrimmed one.
- R5: Minutes are numbered 0 to 2^(CAL_W+1)-1 within the window, which then wraps. Only second 0 of minute m can be trimmed, and only when m < 2*`cal_mag_i`.
- R6: A magnitude of 0 trims no second, whatever the sign.
- R7: A minute holds SEC_PER_MIN seconds. `minute_o` is high exactly in the cycle of the `tick_o` that ends the last second of a minute.
- R8: `ft_512_o` is a square wave with a period of 2^FT_W cycles. It is low for the first half of that period after a restart, and it is independent of `cal_mag_i` and `cal_pos_i`.
- R9: While `stop_i` is high, from the next clock edge on, all outputs are low and every counter is held cleared. After release, timing is the same as after reset.
- R10: `tick_o` is high for exactly one cycle per second, and is never high between the cycles given by R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock, nominally 32,768 Hz |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Halts and clears all counters while high |
| cal_mag_i | input | CAL_W | Trim magnitude N; first 2N minutes of the window are trimmed |
| cal_pos_i | input | 1 | Trim sign: 1 shortens (faster), 0 lengthens (slower) |
| tick_o | output | 1 | One-cycle pulse ending each second |
| minute_o | output | 1 | One-cycle pulse with the tick ending each minute |
| ft_512_o | output | 1 | Uncorrected frequency-test square wave |

## Verification
The outputs decode registered counter state with no further register, so a result is visible in the cycle whose edge sets that state. After a restart, the tick for second s falls at edge count L0-1 plus the lengths of seconds 1 to s. The test wave's level after e edges is bit FT_W-1 of e. The bench counts edges from the falling-edge sample after release, predicts each tick and minute edge from a model of R2 to R7, and compares the outputs at every falling edge. Any pulse outside a predicted edge is recorded as a failure.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_SHORT = 2'd1,
    TRIM_LONG  = 2'd2
  } trim_e;
endpackage

// File: rtl/ft_divider.sv
module ft_divider #(
  parameter int FT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic ft_o
);
  logic [FT_W-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (stop_i) raw_q <= '0;
    else             raw_q <= raw_q + 1'b1;
  end

  assign ft_o = raw_q[FT_W-1];
endmodule

// File: rtl/trim_sequencer.sv
module trim_sequencer
  import calib_pkg::*;
#(
  parameter int CAL_W       = 5,
  parameter int SEC_PER_MIN = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CAL_W-1:0] cal_mag_i,
  input  logic             cal_pos_i,
  output trim_e            trim_o,
  output logic             last_sec_o
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MIN_W = CAL_W + 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic             affected;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (stop_i) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (tick_i) begin
      if (sec_q == SEC_LAST) begin
        sec_q <= '0;
        min_q <= min_q + 1'b1;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  // first 2N minutes of the window, first second only
  assign affected   = (sec_q == '0) && (min_q < {cal_mag_i, 1'b0});
  assign last_sec_o = (sec_q == SEC_LAST);

  always_comb begin
    trim_o = TRIM_NONE;
    if (affected) trim_o = cal_pos_i ? TRIM_SHORT : TRIM_LONG;
  end
endmodule

// File: rtl/trim_divider.sv
module trim_divider
  import calib_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int POST_W = 7
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stop_i,
  input  trim_e trim_i,
  output logic  tick_o
);
  localparam int PRE_NORM = 1 << PRE_W;
  localparam int PRE_LONG = PRE_NORM + (PRE_NORM >> 1);
  localparam logic [PRE_W:0]    LIM_NORM = (PRE_W + 1)'(PRE_NORM - 1);
  localparam logic [PRE_W:0]    LIM_LONG = (PRE_W + 1)'(PRE_LONG - 1);
  localparam logic [POST_W-1:0] POST_MAX = '1;

  logic [PRE_W:0]    pre_q;
  logic [POST_W-1:0] post_q;
  logic              first_unit;
  logic              unit;
  logic [PRE_W:0]    pre_lim;
  logic [POST_W-1:0] step;

  assign first_unit = (post_q == '0);
  // negative trim: stretch the first divide-by-256 period by half
  assign pre_lim    = (trim_i == TRIM_LONG && first_unit) ? LIM_LONG : LIM_NORM;
  assign unit       = (pre_q == pre_lim);
  // positive trim: the first unit counts twice
  assign step       = (trim_i == TRIM_SHORT && first_unit) ? POST_W'(2) : POST_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (stop_i) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (unit) begin
      pre_q  <= '0;
      post_q <= post_q + step;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assign tick_o = unit && (post_q == POST_MAX);
endmodule

// File: rtl/rtc_trim_calibrator.sv
module rtc_trim_calibrator
  import calib_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int POST_W      = 7,
  parameter int CAL_W       = 5,
  parameter int SEC_PER_MIN = 60,
  parameter int FT_W        = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic [CAL_W-1:0] cal_mag_i,
  input  logic             cal_pos_i,
  output logic             tick_o,
  output logic             minute_o,
  output logic             ft_512_o
);
  trim_e trim;
  logic  tick;
  logic  last_sec;

  trim_divider #(.PRE_W(PRE_W), .POST_W(POST_W)) div_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(stop_i),
    .trim_i(trim),
    .tick_o(tick)
  );

  trim_sequencer #(.CAL_W(CAL_W), .SEC_PER_MIN(SEC_PER_MIN)) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_i    (stop_i),
    .tick_i    (tick),
    .cal_mag_i (cal_mag_i),
    .cal_pos_i (cal_pos_i),
    .trim_o    (trim),
    .last_sec_o(last_sec)
  );

  ft_divider #(.FT_W(FT_W)) ft_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(stop_i),
    .ft_o  (ft_512_o)
  );

  assign tick_o   = tick;
  assign minute_o = tick && last_sec;
endmodule

// File: rtl/rtc_trim_calibrator_chk.sv
module rtc_trim_calibrator_chk #(
  parameter int PRE_W  = 8,
  parameter int POST_W = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_i,
  input logic tick_o,
  input logic minute_o,
  input logic ft_512_o
);
  localparam int LEN_W = PRE_W + POST_W + 2;
  localparam logic [LEN_W-1:0] SEC_NORM  = LEN_W'(1 << (PRE_W + POST_W));
  localparam logic [LEN_W-1:0] SEC_SHORT = SEC_NORM - LEN_W'(1 << PRE_W);
  localparam logic [LEN_W-1:0] SEC_LONG  = SEC_NORM + LEN_W'(1 << (PRE_W - 1));

  logic [LEN_W-1:0] len_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || stop_i) begin
      len_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      len_q  <= tick_o ? LEN_W'(1) : len_q + 1'b1;
      if (tick_o) seen_q <= 1'b1;
    end
  end

  // R7
  minute_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    minute_o |-> tick_o);

  // R10
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R9
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!tick_o && !minute_o && !ft_512_o));

  // R2
  sec_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> (len_q == SEC_NORM || len_q == SEC_SHORT || len_q == SEC_LONG));
endmodule

bind rtc_trim_calibrator rtc_trim_calibrator_chk #(.PRE_W(PRE_W), .POST_W(POST_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .stop_i  (stop_i),
  .tick_o  (tick_o),
  .minute_o(minute_o),
  .ft_512_o(ft_512_o)
);

// File: tb/rtc_trim_calibrator_tb_top.sv
module rtc_trim_calibrator_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int PRE_W       = 8;
  localparam int POST_W      = 2;
  localparam int CAL_W       = 3;
  localparam int SEC_PER_MIN = 2;
  localparam int FT_W        = 6;
  localparam int SEC_CYC     = 1 << (PRE_W + POST_W);
  localparam int WIN_MIN     = 1 << (CAL_W + 1);
  localparam int WDOG_LIMIT  = 190000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             stop_i = 1'b0;
  logic [CAL_W-1:0] cal_mag_i = '0;
  logic             cal_pos_i = 1'b0;
  logic             tick_o;
  logic             minute_o;
  logic             ft_512_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  rtc_trim_calibrator #(
    .PRE_W(PRE_W), .POST_W(POST_W), .CAL_W(CAL_W),
    .SEC_PER_MIN(SEC_PER_MIN), .FT_W(FT_W)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i),
    .cal_mag_i(cal_mag_i), .cal_pos_i(cal_pos_i),
    .tick_o(tick_o), .minute_o(minute_o), .ft_512_o(ft_512_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic bit sec_trimmed(int s, int mag);
    int m;
    m = (s / SEC_PER_MIN) % WIN_MIN;
    return ((s % SEC_PER_MIN) == 0) && (m < 2 * mag);
  endfunction

  function automatic int sec_len(int s, int mag, bit pos);
    if (!sec_trimmed(s, mag)) return SEC_CYC;
    return pos ? SEC_CYC - (1 << PRE_W) : SEC_CYC + (1 << (PRE_W - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor from a restart (reset or stop release just applied at a negedge)
  task automatic run_from_zero(input int mag, input bit pos, input int nsec);
    int edges = 0;
    int s = 0;
    int nxt = sec_len(0, mag, pos) - 1;
    int ft_bad = 0;
    int spur = 0;
    int ft_last_act = 0;
    int ft_last_exp = 0;
    string tag;
    while (s < nsec) begin
      @(negedge clk_i);
      edges++;
      if (int'(ft_512_o) != ((edges >> (FT_W - 1)) & 1)) begin
        ft_bad++;
        ft_last_act = int'(ft_512_o);
        ft_last_exp = (edges >> (FT_W - 1)) & 1;
      end
      if (edges == nxt) begin
        if (mag == 0)                  tag = "R6 zero trim second";
        else if (!sec_trimmed(s, mag)) tag = "R2/R5 untrimmed second";
        else if (pos)                  tag = "R3/R5 shortened second";
        else                           tag = "R4/R5 lengthened second";
        if (s == 0) tag = {"R1 ", tag};
        chk(tick_o == 1'b1, tag, int'(tick_o), 1);
        chk(minute_o == ((s % SEC_PER_MIN) == SEC_PER_MIN - 1), "R7 minute pulse",
            int'(minute_o), int'((s % SEC_PER_MIN) == SEC_PER_MIN - 1));
        s++;
        nxt += sec_len(s, mag, pos);
      end else if (tick_o || minute_o) begin
        spur++;
      end
    end
    chk(ft_bad == 0, "R8 test wave", ft_last_act, ft_last_exp);
    chk(spur == 0, "R10 spurious tick", spur, 0);
  endtask

  task automatic run_seg(input int mag, input bit pos, input int nsec);
    @(negedge clk_i);
    stop_i    = 1'b1;
    cal_mag_i = CAL_W'(mag);
    cal_pos_i = pos;
    repeat (3) begin
      @(negedge clk_i);
      chk(!tick_o && !minute_o && !ft_512_o, "R9 stopped outputs",
          int'({tick_o, minute_o, ft_512_o}), 0);
    end
    stop_i = 1'b0;
    run_from_zero(mag, pos, nsec);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > WDOG_LIMIT) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    cal_mag_i = CAL_W'(3);
    cal_pos_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!tick_o && !minute_o && !ft_512_o, "R1 reset outputs",
        int'({tick_o, minute_o, ft_512_o}), 0);
    rst_ni = 1'b1;
    run_from_zero(3, 1'b1, 8);

    // directed corners
    run_seg(0, 1'b1, 6);
    run_seg(0, 1'b0, 6);
    run_seg(7, 1'b1, 34);
    run_seg(7, 1'b0, 34);
    run_seg(1, 1'b0, 8);

    // constrained random segments
    for (int k = 0; k < 3; k++) begin
      int m;
      bit p;
      m = int'($urandom_range(1, (1 << CAL_W) - 1));
      p = 1'($urandom_range(0, 1));
      run_seg(m, p, 10);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule